// File: doc/BRIEF.md
# Character LCD Write Interface

This block sits between a client and a character LCD module that is only ever written. The client puts an 8-bit value on `wr_value`, says with `wr_is_char` whether the value is a character to show (1) or an instruction (0), and pulses `wr_req` while `ready` is high. The block drives the module's 8-bit data bus, its register-select line and a single enable pulse one slow-clock period wide. It then keeps `ready` low until the module has had time to execute the write. Busy status is never read back: the read/write line stays at write, and completion comes from a fixed wait counted in slow-clock periods. The clear and home instructions get a longer wait.

A free-running divider on the fast input clock produces a one-cycle tick each time it wraps. The tick paces all bus timing, so one slow period is `2**DIV_BITS` fast cycles. After every reset the block configures the module by itself with four instructions: 0x30 (8-bit bus, one line), 0x0C (display on, cursor off), 0x06 (auto-increment, no shift) and 0x01 (clear). Only after the long wait that follows the clear does `ready` rise for the first time.

The controller has four states. SETUP holds the latched value on the bus until the next tick. STROBE raises the enable for one slow period. WAIT counts the execution delay. IDLE raises `ready`. The transitions are:
- reset goes to SETUP with init word 0;
- SETUP goes to STROBE on a tick;
- STROBE goes to WAIT on a tick, which also loads the timer;
- WAIT goes to SETUP when the timer expires and init words remain, loading the next word;
- WAIT goes to IDLE when the timer expires and initialization is done;
- IDLE goes to SETUP on an accepted request.

Top module: `lcd_write_if`

## Requirements
- R1: While reset is asserted and just after it is released, `ready` and `lcd_en` are 0 and `lcd_rw` is 0.
- R2: After every reset, four instruction writes (`lcd_rs`=0) appear on the bus without any request, with values 0x30, 0x0C, 0x06 and 0x01, in that order.
- R3: During initialization `ready` stays 0. From the falling enable of each of the first three init writes to the rising enable of the next write there are (SHORT_WAIT+1)·2^DIV_BITS fast cycles. `ready` first rises LONG_WAIT·2^DIV_BITS fast cycles after the enable of the clear falls.
- R4: While `lcd_en` is high, `lcd_data` equals the accepted `wr_value` and `lcd_rs` equals the accepted `wr_is_char` (1 = character, 0 = instruction).
- R5: `lcd_rw` is 0 at all times.
- R6: Each enable pulse lasts exactly 2^DIV_BITS fast cycles, and `lcd_data`/`lcd_rs` do not change while it is high.
- R7: After a character write, or after an instruction write other than 0x01, 0x02 and 0x03, `ready` rises exactly SHORT_WAIT·2^DIV_BITS fast cycles after the enable falls.
- R8: After an instruction write of 0x01 (clear) or 0x02/0x03 (home), `ready` rises exactly LONG_WAIT·2^DIV_BITS fast cycles after the enable falls.
- R9: A request while `ready` is 1 is accepted: `ready` is 0 after the next clock edge, and the enable rises within 2^DIV_BITS fast cycles after that edge. `lcd_en` is never high while `ready` is 1.
- R10: A request while `ready` is 0 is ignored. It changes neither the value on the bus for the write in progress nor the count of writes: no extra enable pulse follows once `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (about 12 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled while `ready` is high |
| wr_is_char | input | 1 | 1 = character write, 0 = instruction |
| wr_value | input | 8 | Character code or instruction byte |
| ready | output | 1 | High only while idle and able to accept a request |
| lcd_data | output | 8 | Module data bus |
| lcd_rs | output | 1 | Register select: 1 character, 0 instruction |
| lcd_rw | output | 1 | Read/write line, always 0 (write) |
| lcd_en | output | 1 | Enable strobe, one slow period wide |

## Verification
The bench builds the block with DIV_BITS=2, SHORT_WAIT=2 and LONG_WAIT=5, so a slow period is 4 fast cycles and a full write takes only a few dozen cycles. With these values the bench can sweep all 256 byte values as characters and again as instructions. The instruction sweep crosses every value that does and does not select the long wait, and every expected pulse width and gap is computed from those three numbers. Short waits also keep repeated resets and the full init sequence cheap, so the bench resets mid-sweep and checks the init sequence again. It also injects a request during every busy interval.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [1:0] {
        ST_SETUP  = 2'd0,
        ST_STROBE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_IDLE   = 2'd3
    } lcdw_state_t;

    localparam int INIT_COUNT = 4;
    localparam int INIT_IDX_W = $clog2(INIT_COUNT);

    // Power-up configuration words, issued in index order.
    function automatic logic [7:0] init_word(input logic [INIT_IDX_W-1:0] idx);
        logic [7:0] w;
        unique case (idx)
            2'd0:    w = 8'h30;  // 8-bit bus, one line
            2'd1:    w = 8'h0C;  // display on, cursor off
            2'd2:    w = 8'h06;  // increment, no shift
            default: w = 8'h01;  // clear
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lcdw_tick_gen.sv
module lcdw_tick_gen #(
    parameter int DIV_BITS = 7
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV_BITS == 0) begin : g_nodiv
            assign tick_o = 1'b1;
        end else begin : g_div
            logic [DIV_BITS-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_q + 1'b1;
            end
            // one tick per wrap: the moment the top bit would roll over
            assign tick_o = &cnt_q;
        end
    endgenerate
endmodule

// File: rtl/lcdw_cmd_class.sv
module lcdw_cmd_class (
    input  logic       is_char_i,
    input  logic [7:0] value_i,
    output logic       long_o
);
    // clear = 0x01, home = 0x02/0x03, only as instructions
    always_comb begin
        long_o = !is_char_i && (value_i == 8'h01 || value_i[7:1] == 7'h01);
    end
endmodule

// File: rtl/lcdw_wait_timer.sv
module lcdw_wait_timer #(
    parameter int SHORT_WAIT = 4,
    parameter int LONG_WAIT  = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    input  logic long_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int MAX_WAIT = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_WAIT - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_WAIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= long_i ? LONG_LOAD : SHORT_LOAD;
        end else if (run_i && tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && tick_i && (cnt_q == '0);
endmodule

// File: rtl/lcd_write_if.sv
module lcd_write_if #(
    parameter int DIV_BITS   = 7,
    parameter int SHORT_WAIT = 4,
    parameter int LONG_WAIT  = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic       wr_is_char,
    input  logic [7:0] wr_value,
    output logic       ready,
    output logic [7:0] lcd_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en
);
    import lcdw_pkg::*;

    localparam logic [INIT_IDX_W-1:0] LAST_INIT = INIT_IDX_W'(INIT_COUNT - 1);

    lcdw_state_t state_q, state_d;
    logic [7:0]  data_q;
    logic        rs_q;
    logic [INIT_IDX_W-1:0] idx_q;
    logic        init_q;
    logic        tick, expire, long_wait;

    lcdw_tick_gen #(.DIV_BITS(DIV_BITS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    lcdw_cmd_class u_class (
        .is_char_i(rs_q), .value_i(data_q), .long_o(long_wait)
    );

    lcdw_wait_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .load_i(state_q == ST_STROBE && tick),
        .long_i(long_wait),
        .run_i(state_q == ST_WAIT),
        .expire_o(expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETUP;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP:  if (tick)   state_d = ST_STROBE;
            ST_STROBE: if (tick)   state_d = ST_WAIT;
            ST_WAIT:   if (expire) state_d = (init_q && idx_q != LAST_INIT) ? ST_SETUP : ST_IDLE;
            ST_IDLE:   if (wr_req) state_d = ST_SETUP;
            default:               state_d = ST_SETUP;
        endcase
    end

    // bus value and init progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= init_word('0);
            rs_q   <= 1'b0;
            idx_q  <= '0;
            init_q <= 1'b1;
        end else begin
            if (state_q == ST_WAIT && expire && init_q) begin
                if (idx_q != LAST_INIT) begin
                    idx_q  <= idx_q + 1'b1;
                    data_q <= init_word(idx_q + 1'b1);
                    rs_q   <= 1'b0;
                end else begin
                    init_q <= 1'b0;
                end
            end
            if (state_q == ST_IDLE && wr_req) begin
                data_q <= wr_value;
                rs_q   <= wr_is_char;
            end
        end
    end

    // outputs
    always_comb begin
        ready    = (state_q == ST_IDLE);
        lcd_en   = (state_q == ST_STROBE);
        lcd_rw   = 1'b0;
        lcd_data = data_q;
        lcd_rs   = rs_q;
    end
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
    parameter int DIV_BITS   = 7,
    parameter int SHORT_WAIT = 4,
    parameter int LONG_WAIT  = 160
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_req,
    input logic       ready,
    input logic [7:0] lcd_data,
    input logic       lcd_rs,
    input logic       lcd_en
);
    localparam int PER = 1 << DIV_BITS;

    int unsigned en_len, gap_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_len  <= 0;
            gap_len <= 0;
        end else begin
            en_len  <= lcd_en ? en_len + 1 : 0;
            gap_len <= lcd_en ? 0 : ((gap_len == 32'hFFFF_FFFF) ? gap_len : gap_len + 1);
        end
    end

    AST_NO_EN_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !lcd_en);  // R9

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready && wr_req |=> !ready);  // R9

    AST_BUS_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && $past(lcd_en) |-> $stable(lcd_data) && $stable(lcd_rs));  // R6

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> en_len == PER);  // R6

    AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (gap_len == SHORT_WAIT * PER || gap_len == LONG_WAIT * PER));  // R7
endmodule

bind lcd_write_if lcdw_checker #(
    .DIV_BITS(DIV_BITS), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .ready(ready),
    .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_en(lcd_en)
);

// File: tb/sim_lcd_write_if.sv
module sim_lcd_write_if;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_BITS   = 2;
    localparam int SHORT_WAIT = 2;
    localparam int LONG_WAIT  = 5;
    localparam int PER        = 1 << DIV_BITS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0;
    logic       wr_is_char = 1'b0;
    logic [7:0] wr_value = 8'h00;
    logic       ready, lcd_rs, lcd_rw, lcd_en;
    logic [7:0] lcd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_write_if #(.DIV_BITS(DIV_BITS), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_is_char(wr_is_char),
        .wr_value(wr_value), .ready(ready), .lcd_data(lcd_data), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_en(lcd_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // waits for an enable pulse, checks its fields and width
    task automatic see_pulse(input logic [7:0] exp_v, input bit exp_rs, input string tag);
        int n = 0;
        while (!lcd_en && n < 40 * PER) begin @(negedge clk); n++; end
        chk(lcd_en == 1'b1, {tag, " R2 pulse seen"}, lcd_en, 1);
        chk(lcd_data == exp_v, {tag, " R4 data"}, lcd_data, exp_v);
        chk(lcd_rs == exp_rs, {tag, " R4 rs"}, lcd_rs, exp_rs);
        chk(lcd_rw == 1'b0, {tag, " R5 rw"}, lcd_rw, 0);
        begin
            int w = 1;
            bit steady = 1'b1;
            forever begin
                @(negedge clk);
                if (!lcd_en) break;
                if (lcd_data != exp_v || lcd_rs != exp_rs) steady = 1'b0;
                w++;
            end
            chk(w == PER, {tag, " R6 width"}, w, PER);
            chk(steady, {tag, " R6 stable"}, steady, 1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0 && lcd_en == 1'b0 && lcd_rw == 1'b0, "R1 in reset",
            {ready, lcd_en, lcd_rw}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0 && lcd_en == 1'b0, "R1 after release", {ready, lcd_en}, 0);
    endtask

    task automatic check_init();
        logic [7:0] words [4] = '{8'h30, 8'h0C, 8'h06, 8'h01};
        for (int i = 0; i < 4; i++) begin
            int g = 0;
            bit ready_seen = 1'b0;
            see_pulse(words[i], 1'b0, "R2 init");
            if (i < 3) begin
                while (!lcd_en && g < 100 * PER) begin
                    if (ready) ready_seen = 1'b1;
                    g++; @(negedge clk);
                end
                chk(!ready_seen, "R3 ready low in init", ready_seen, 0);
                chk(g == (SHORT_WAIT + 1) * PER, "R3 init gap", g, (SHORT_WAIT + 1) * PER);
            end else begin
                while (!ready && !lcd_en && g < 100 * PER) begin g++; @(negedge clk); end
                chk(ready == 1'b1, "R3 ready after clear", ready, 1);
                chk(g == LONG_WAIT * PER, "R3 clear wait", g, LONG_WAIT * PER);
            end
        end
    endtask

    task automatic do_write(input bit is_char, input logic [7:0] v, input bit stray);
        int n;
        int g = 0;
        bit long_w = !is_char && (v == 8'h01 || v == 8'h02 || v == 8'h03);
        int exp_gap = (long_w ? LONG_WAIT : SHORT_WAIT) * PER;
        while (!ready) @(negedge clk);
        wr_req = 1'b1; wr_is_char = is_char; wr_value = v;
        @(negedge clk);
        wr_req = 1'b0;
        chk(ready == 1'b0, "R9 ready drops", ready, 0);
        n = 0;
        if (stray) begin
            wr_req = 1'b1; wr_is_char = !is_char; wr_value = ~v;
            @(negedge clk);
            wr_req = 1'b0;
            n = 1;
        end
        while (!lcd_en && n < 4 * PER) begin @(negedge clk); n++; end
        chk(n >= 1 && n <= PER, "R9 enable latency", n, PER);
        see_pulse(v, is_char, stray ? "R10 busy req" : "R4 write");
        while (!ready && !lcd_en && g < 100 * PER) begin g++; @(negedge clk); end
        if (long_w) chk(g == exp_gap, "R8 long wait", g, exp_gap);
        else        chk(g == exp_gap, "R7 short wait", g, exp_gap);
        if (stray) begin
            bit quiet = 1'b1;
            repeat (3 * PER) begin
                @(negedge clk);
                if (lcd_en || !ready) quiet = 1'b0;
            end
            chk(quiet, "R10 no extra write", quiet, 1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset();
        check_init();
        for (int v = 0; v < 256; v++) do_write(1'b1, 8'(v), (v % 16) == 5);
        for (int v = 0; v < 256; v++) do_write(1'b0, 8'(v), (v % 16) == 9);
        // reset in the middle of a write, then init must repeat
        while (!ready) @(negedge clk);
        wr_req = 1'b1; wr_is_char = 1'b1; wr_value = 8'h41;
        @(negedge clk); wr_req = 1'b0;
        repeat (PER + 1) @(negedge clk);
        do_reset();
        check_init();
        do_write(1'b0, 8'h02, 1'b1);
        do_write(1'b1, 8'hFF, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule